// File: doc/BRIEF.md
# DMA Bus Cycle Splitter

This block sits between a DMA transfer engine and an external bus that may be narrower than the transfer unit. The engine hands over one job through a valid/ready handshake. A job carries a transfer size and a count of transfers, and the bus width, bus type, strobe mode, idle length and request detection mode are captured along with it. For every transfer the block waits for the peripheral's DMA request. It then issues as many one-clock bus cycles as the width demands. During each bus cycle it drives chip select and the acknowledge strobe. During the bus cycles of the final transfer it also drives the end-of-transfer strobe.

Between sub-cycles of one transfer, chip select either stays asserted or drops for one clock, depending on the mode. The acknowledge and end strobes always follow chip select, so they are divided in exactly the same way. After every transfer a programmable idle gap follows, with a minimum of one clock, so that two acknowledges can never merge. The request line is only looked at on transfer boundaries, never in the middle of a transfer. One clock after the last bus cycle of the job, a done pulse is raised.

Top module: `dma_bus_splitter`

## Requirements
- R1: A transfer issues N = max(size_bytes / width_bytes, 1) bus cycles. The size codes are 0=1 byte, 1=2 bytes, 2=4 bytes, 3=16 bytes, and 4 or above=32 bytes. The width codes are 0=8 bits, 1=16 bits, and 2 or 3=32 bits.
- R2: When `cfg_mpx_i`=1 and the size code is 2 (4 bytes), the transfer is one burst bus cycle regardless of width.
- R3: When `cfg_cs_split_i`=0, chip select and acknowledge stay high for N consecutive clocks per transfer.
- R4: When `cfg_cs_split_i`=1, chip select drops for exactly one clock between sub-cycles. Acknowledge and end strobe are high only in clocks where chip select is high.
- R5: The end strobe is high on every bus cycle of the final transfer of the job, and on no other cycle.
- R6: After each transfer, chip select and acknowledge stay low for max(`cfg_idle_i`,1) clocks before any further bus cycle. An idle value of 0 acts as 1.
- R7: When `cfg_dreq_edge_i`=1, a transfer starts only after a rising edge of `dreq_i`, seen through a two-flop synchronizer. A rising edge during the gap is held as one pending request. A rising edge during bus cycles is ignored.
- R8: When `cfg_dreq_edge_i`=0, a transfer starts at a boundary where the synchronized `dreq_i` level is high.
- R9: `req_ready_o` is high only while no job is active. A job count of 0 acts as 1. `done_o` is a single-clock pulse in the first gap clock after the job's last bus cycle.
- R10: After reset, `req_ready_o`=1 and all strobes and `done_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Job offered |
| req_ready_o | output | 1 | Block can accept a job |
| req_size_i | input | 3 | Transfer size code |
| req_count_i | input | COUNT_W | Number of transfers in the job |
| cfg_width_i | input | 2 | External bus width code |
| cfg_mpx_i | input | 1 | Multiplexed address/data bus |
| cfg_cs_split_i | input | 1 | Negate chip select between sub-cycles |
| cfg_idle_i | input | IDLE_W | Idle clocks after each transfer |
| cfg_dreq_edge_i | input | 1 | 1 = edge request detection, 0 = level |
| dreq_i | input | 1 | Asynchronous DMA request |
| cs_o | output | 1 | Chip select |
| dack_o | output | 1 | DMA acknowledge strobe |
| tend_o | output | 1 | Transfer-end strobe |
| done_o | output | 1 | Job complete pulse |

## Verification
On every cycle, the assertions check the following:
- the end strobe is never high without chip select and acknowledge;
- no strobe overlaps `done_o` or an idle handshake;
- `done_o` lasts one clock;
- an accepted job drops ready at once.

Other properties depend on the history of the request line and the captured configuration, so only the bench's scenarios can show them. These are the exact number of sub-cycles per size and width, the single burst on a multiplexed bus, the one-clock chip select gaps, the idle length, and the loss of a request edge raised during bus cycles. The reference model covers these scenarios clock by clock.

// File: rtl/dma_split_pkg.sv
package dma_split_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_WAIT = 3'd1,
        ST_BUS  = 3'd2,
        ST_NEG  = 3'd3,
        ST_GAP  = 3'd4
    } split_st_e;
endpackage

// File: rtl/dsp_beat_calc.sv
module dsp_beat_calc #(
    parameter int SUB_W = 6
) (
    input  logic [2:0]       size_i,
    input  logic [1:0]       width_i,
    input  logic             mpx_i,
    output logic [SUB_W-1:0] last_o
);
    logic [2:0] size_log;
    logic [2:0] width_log;
    logic [2:0] diff_log;

    always_comb begin
        if (size_i <= 3'd2)      size_log = size_i;
        else if (size_i == 3'd3) size_log = 3'd4;
        else                     size_log = 3'd5;
        width_log = (width_i > 2'd2) ? 3'd2 : {1'b0, width_i};
        diff_log  = (size_log > width_log) ? (size_log - width_log) : 3'd0;
        // one burst cycle for a 4-byte access on a multiplexed bus
        if (mpx_i && (size_i == 3'd2)) diff_log = 3'd0;
        last_o = SUB_W'((32'd1 << diff_log) - 32'd1);
    end
endmodule

// File: rtl/dsp_dreq_sync.sv
module dsp_dreq_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic dreq_i,
    output logic level_o,
    output logic rise_o
);
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= dreq_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign level_o = sync_q;
    assign rise_o  = sync_q & ~prev_q;
endmodule

// File: rtl/dma_bus_splitter.sv
module dma_bus_splitter
    import dma_split_pkg::*;
#(
    parameter int COUNT_W = 8,
    parameter int IDLE_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid_i,
    output logic               req_ready_o,
    input  logic [2:0]         req_size_i,
    input  logic [COUNT_W-1:0] req_count_i,
    input  logic [1:0]         cfg_width_i,
    input  logic               cfg_mpx_i,
    input  logic               cfg_cs_split_i,
    input  logic [IDLE_W-1:0]  cfg_idle_i,
    input  logic               cfg_dreq_edge_i,
    input  logic               dreq_i,
    output logic               cs_o,
    output logic               dack_o,
    output logic               tend_o,
    output logic               done_o
);
    localparam int SUB_W = $clog2(32) + 1;

    typedef struct packed {
        split_st_e          st;
        logic [COUNT_W-1:0] left;
        logic [SUB_W-1:0]   sub;
        logic [SUB_W-1:0]   last;
        logic [IDLE_W-1:0]  gap;
        logic [IDLE_W-1:0]  idle;
        logic               split;
        logic               edge_m;
        logic               pend;
        logic               done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [SUB_W-1:0] calc_last;
    logic dreq_lvl, dreq_rise, trig;

    dsp_beat_calc #(.SUB_W(SUB_W)) u_calc (
        .size_i  (req_size_i),
        .width_i (cfg_width_i),
        .mpx_i   (cfg_mpx_i),
        .last_o  (calc_last)
    );

    dsp_dreq_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .dreq_i  (dreq_i),
        .level_o (dreq_lvl),
        .rise_o  (dreq_rise)
    );

    assign trig = ctl_q.edge_m ? (ctl_q.pend | dreq_rise) : dreq_lvl;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid_i) begin
                    ctl_d.st     = ST_WAIT;
                    ctl_d.left   = (req_count_i == '0) ? COUNT_W'(1) : req_count_i;
                    ctl_d.last   = calc_last;
                    ctl_d.idle   = (cfg_idle_i == '0) ? IDLE_W'(1) : cfg_idle_i;
                    ctl_d.split  = cfg_cs_split_i;
                    ctl_d.edge_m = cfg_dreq_edge_i;
                    ctl_d.pend   = 1'b0;
                end
            end
            ST_WAIT: begin
                if (trig) begin
                    ctl_d.st   = ST_BUS;
                    ctl_d.sub  = ctl_q.last;
                    ctl_d.pend = 1'b0;
                end
            end
            ST_BUS: begin
                if (ctl_q.sub == '0) begin
                    ctl_d.st   = ST_GAP;
                    ctl_d.gap  = ctl_q.idle - IDLE_W'(1);
                    ctl_d.left = ctl_q.left - COUNT_W'(1);
                    ctl_d.done = (ctl_q.left == COUNT_W'(1));
                end else begin
                    ctl_d.sub = ctl_q.sub - SUB_W'(1);
                    ctl_d.st  = ctl_q.split ? ST_NEG : ST_BUS;
                end
            end
            ST_NEG: ctl_d.st = ST_BUS;
            ST_GAP: begin
                if (ctl_q.edge_m && dreq_rise) ctl_d.pend = 1'b1;
                if (ctl_q.gap == '0) ctl_d.st = (ctl_q.left == '0) ? ST_IDLE : ST_WAIT;
                else                 ctl_d.gap = ctl_q.gap - IDLE_W'(1);
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_ready_o = (ctl_q.st == ST_IDLE);
    assign cs_o        = (ctl_q.st == ST_BUS);
    assign dack_o      = (ctl_q.st == ST_BUS);
    assign tend_o      = (ctl_q.st == ST_BUS) && (ctl_q.left == COUNT_W'(1));
    assign done_o      = ctl_q.done;
endmodule

// File: rtl/dsp_checker.sv
module dsp_checker (
    input logic clk,
    input logic rst_n,
    input logic req_valid_i,
    input logic req_ready_o,
    input logic cs_o,
    input logic dack_o,
    input logic tend_o,
    input logic done_o
);
    a_r5_tend_inside_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        tend_o |-> (cs_o && dack_o));

    a_r4_dack_follows_cs: assert property (@(posedge clk) disable iff (!rst_n)
        dack_o |-> cs_o);

    a_r6_done_in_gap: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!cs_o && !dack_o));

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r9_accept_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o) |=> !req_ready_o);

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready_o |-> (!cs_o && !dack_o && !tend_o));
endmodule

bind dma_bus_splitter dsp_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .cs_o        (cs_o),
    .dack_o      (dack_o),
    .tend_o      (tend_o),
    .done_o      (done_o)
);

// File: tb/tb_dma_bus_splitter.sv
module tb_dma_bus_splitter;
    localparam int CLK_PERIOD = 10;
    localparam int COUNT_W    = 8;
    localparam int IDLE_W     = 3;
    localparam int WATCHDOG   = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [2:0] req_size = '0;
    logic [COUNT_W-1:0] req_count = '0;
    logic [1:0] cfg_width = '0;
    logic cfg_mpx = 1'b0, cfg_split = 1'b0, cfg_edge = 1'b1;
    logic [IDLE_W-1:0] cfg_idle = '0;
    logic dreq = 1'b0;
    logic cs, dack, tend, done;

    int checks = 0, errors = 0;
    int dack_cyc = 0, tend_cyc = 0, done_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_bus_splitter #(.COUNT_W(COUNT_W), .IDLE_W(IDLE_W)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
        .req_size_i(req_size), .req_count_i(req_count), .cfg_width_i(cfg_width),
        .cfg_mpx_i(cfg_mpx), .cfg_cs_split_i(cfg_split), .cfg_idle_i(cfg_idle),
        .cfg_dreq_edge_i(cfg_edge), .dreq_i(dreq), .cs_o(cs), .dack_o(dack),
        .tend_o(tend), .done_o(done)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int beats(input int size, input int width, input bit mpx);
        int bytes = (size <= 2) ? (1 << size) : ((size == 3) ? 16 : 32);
        int wb    = 1 << ((width > 2) ? 2 : width);
        int n     = bytes / wb;
        if (n < 1) n = 1;
        if (mpx && size == 2) n = 1;
        return n;
    endfunction

    // behavioural reference model
    int  m_mode, m_left, m_beats, m_done_i, m_gap, m_gcnt;
    bit  m_split, m_edge, m_pend, m_neg, m_done;
    bit  m_s1, m_s2, m_s3;

    always @(posedge clk) begin
        bit rise, lvl;
        if (!rst_n) begin
            m_mode = 0; m_left = 0; m_pend = 0; m_neg = 0; m_done = 0;
            m_s1 = 0; m_s2 = 0; m_s3 = 0;
        end else begin
            rise = m_s2 && !m_s3;
            lvl  = m_s2;
            m_done = 0;
            case (m_mode)
                0: if (req_valid) begin
                    m_mode  = 1;
                    m_left  = (req_count == 0) ? 1 : int'(req_count);
                    m_beats = beats(int'(req_size), int'(cfg_width), cfg_mpx);
                    m_split = cfg_split;
                    m_gap   = (cfg_idle == 0) ? 1 : int'(cfg_idle);
                    m_edge  = cfg_edge;
                    m_pend  = 0;
                end
                1: if (m_edge ? (m_pend || rise) : lvl) begin
                    m_mode = 2; m_done_i = 0; m_pend = 0; m_neg = 0;
                end
                2: if (m_neg) m_neg = 0;
                   else begin
                       m_done_i++;
                       if (m_done_i == m_beats) begin
                           m_mode = 3; m_gcnt = 0; m_left--;
                           m_done = (m_left == 0);
                       end else if (m_split) m_neg = 1;
                   end
                default: begin
                    if (m_edge && rise) m_pend = 1;
                    m_gcnt++;
                    if (m_gcnt == m_gap) m_mode = (m_left == 0) ? 0 : 1;
                end
            endcase
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = dreq;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            bit e_cs;
            e_cs = (m_mode == 2) && !m_neg;
            check(req_ready === (m_mode == 0), "R9 ready", int'(req_ready), int'(m_mode == 0));
            check(cs === e_cs, "R1 R3 R4 R6 R7 R8 cs", int'(cs), int'(e_cs));
            check(dack === e_cs, "R4 dack", int'(dack), int'(e_cs));
            check(tend === (e_cs && m_left == 1), "R5 tend", int'(tend), int'(e_cs && m_left == 1));
            check(done === m_done, "R9 done", int'(done), int'(m_done));
            if (dack === 1'b1) dack_cyc++;
            if (tend === 1'b1) tend_cyc++;
            if (done === 1'b1) done_cnt++;
        end
    end

    task automatic start_job(input int size, input int count, input int width, input bit mpx,
                             input bit split, input int idle, input bit edge_m);
        @(negedge clk); #1;
        dack_cyc = 0; tend_cyc = 0; done_cnt = 0;
        req_size = 3'(size); req_count = COUNT_W'(count); cfg_width = 2'(width);
        cfg_mpx = mpx; cfg_split = split; cfg_idle = IDLE_W'(idle); cfg_edge = edge_m;
        req_valid = 1'b1;
        @(negedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic pulse();
        @(negedge clk); #1 dreq = 1'b1;
        repeat (2) @(negedge clk);
        #1 dreq = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_edge();
        while (!req_ready) pulse();
        repeat (2) @(negedge clk);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                #1 rst_n = 1'b1;
                @(negedge clk); #1;
                // R10 reset state
                check(req_ready === 1'b1, "R10 ready", int'(req_ready), 1);
                check({cs, dack, tend, done} === 4'b0, "R10 strobes", int'({cs, dack, tend, done}), 0);

                // longword over 8-bit bus, merged chip select, two transfers
                start_job(2, 2, 0, 0, 0, 2, 1);
                finish_edge();
                check(dack_cyc == 8, "R1 R3 long on 8-bit", dack_cyc, 8);
                check(tend_cyc == 4, "R5 final transfer only", tend_cyc, 4);
                check(done_cnt == 1, "R9 one done pulse", done_cnt, 1);

                // 16 bytes over 16-bit bus, split chip select, idle 0 acts as 1
                start_job(3, 1, 1, 0, 1, 0, 1);
                finish_edge();
                check(dack_cyc == 8, "R1 R4 16B on 16-bit", dack_cyc, 8);
                check(tend_cyc == 8, "R5 single transfer", tend_cyc, 8);

                // multiplexed bus: longword is one burst even on 8-bit width
                start_job(2, 3, 0, 1, 1, 1, 1);
                finish_edge();
                check(dack_cyc == 3, "R2 burst", dack_cyc, 3);

                // count 0 acts as 1, word on 32-bit bus
                start_job(1, 0, 2, 0, 0, 1, 1);
                finish_edge();
                check(dack_cyc == 1, "R1 R9 count zero", dack_cyc, 1);

                // level detection with request held high
                start_job(0, 4, 2, 0, 0, 3, 0);
                @(negedge clk); #1 dreq = 1'b1;
                while (!req_ready) @(negedge clk);
                #1 dreq = 1'b0;
                repeat (4) @(negedge clk);
                check(dack_cyc == 4, "R8 R6 level", dack_cyc, 4);
                check(done_cnt == 1, "R9 level done", done_cnt, 1);

                // edge raised during bus cycles is lost
                start_job(4, 2, 0, 0, 0, 1, 1);
                pulse();
                while (dack !== 1'b1) @(negedge clk);
                pulse();
                repeat (60) @(negedge clk);
                check(dack_cyc == 32, "R7 edge in bus ignored", dack_cyc, 32);
                check(req_ready === 1'b0, "R7 still waiting", int'(req_ready), 0);
                finish_edge();
                check(dack_cyc == 64, "R7 second transfer", dack_cyc, 64);
                check(tend_cyc == 32, "R5 32B final", tend_cyc, 32);
            end
            begin
                repeat (WATCHDOG) @(posedge clk);
                errors++;
                $display("FAIL R9 watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule